// File: doc/BRIEF.md
# Constant Off-Time Current Chopper

This block regulates the current in one winding bridge by chopping. While the bridge is on, a digital sense comparator reports whether the sensed current is above the reference. A trip of that comparator switches the bridge off for a programmed number of clock cycles. When the interval expires, the bridge is switched on again. The power stage inserts its own dead time afterwards, so the effective off time is the programmed count plus that dead time.

Each on phase begins with a blanking window. During this window the comparator is ignored, so that the recovery spike at turn-on cannot cause a trip. A minimum on-time is also enforced. If a trip is seen after blanking but before the minimum on-time has elapsed, the trip is remembered and takes effect when the minimum on-time is reached.

The comparator input is asynchronous and passes through a two-flop synchronizer. The off-time count comes from a register. It is captured at the trip, so a new value applies from the next trip onward. An instance is used per bridge.

Top module: `chop_ctrl`

## Requirements
- R1: After reset the controller is in the on phase with blanking active: `phase_o` = 01, and `bridge_on_o` follows `en_i`.
- R2: For the first BLANK_CYC cycles of every on phase, `phase_o` = 01. A comparator pulse that is seen only inside this window never causes a trip.
- R3: The bridge stays on for at least MIN_ON_CYC cycles of each on phase. A comparator high seen after blanking but before that count is held pending. It trips the bridge when the count is reached, even if the comparator has fallen by then.
- R4: Once the minimum on-time has passed, `cmp_i` high before rising edge k turns the bridge off after edge k+2 (two synchronizer stages).
- R5: The off phase lasts exactly max(T,1) cycles, where T is `toff_i` at the trip, whatever `cmp_i` does during it. A value of T = 0 gives one cycle.
- R6: When the off interval ends, the controller re-enters the on phase with blanking (`phase_o` = 01, `bridge_on_o` = 1).
- R7: `toff_i` is captured at the trip. A change during an off phase affects only later off phases.
- R8: `en_i` low forces `bridge_on_o` low at once and moves the state to disabled (`phase_o` = 00) at the next edge. When `en_i` returns high, a fresh blanked on phase starts.
- R9: `phase_o` encodes the state as follows: 00 disabled, 01 on with blanking, 10 on after blanking, 11 off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable; low forces the bridge off |
| cmp_i | input | 1 | Asynchronous sense comparator, high when current is above reference |
| toff_i | input | CNT_W | Off interval in clock cycles, captured at each trip |
| bridge_on_o | output | 1 | Bridge on request |
| phase_o | output | 2 | Controller state, encoded as in R9 |

## Verification
The embedded properties assume that `en_i` and `toff_i` are synchronous to the clock. They also assume that MIN_ON_CYC exceeds BLANK_CYC, so a trip is only ever possible after blanking. Only `cmp_i` may change at any time, and it is used solely through the synchronizer.

The stimulus respects these assumptions. It changes every input on the falling edge and holds comparator pulses for whole cycles. Comparator pulses are placed relative to the start of a fresh on phase, so that they land inside the blanking window, in the pending window, and after the minimum on-time. Enable is dropped both during an off phase and during an on phase.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {
    ST_DIS   = 2'b00,
    ST_BLANK = 2'b01,
    ST_ON    = 2'b10,
    ST_OFF   = 2'b11
  } chop_state_e;
endpackage

// File: rtl/chop_sync.sv
module chop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     sr_q[g] <= 1'b0;
        else if (g == 0) sr_q[g] <= d_i;
        else             sr_q[g] <= sr_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/chop_on_timer.sv
module chop_on_timer #(
  parameter int BLANK_CYC  = 4,
  parameter int MIN_ON_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic blank_last_o,
  output logic min_done_o
);
  localparam int ON_W = $clog2(MIN_ON_CYC + 1);
  localparam logic [ON_W-1:0] LAST_CNT  = ON_W'(MIN_ON_CYC - 1);
  localparam logic [ON_W-1:0] BLANK_END = ON_W'(BLANK_CYC - 1);

  logic [ON_W-1:0] cnt_q;

  // counts cycles since turn-on, saturating once minimum on-time is met
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != LAST_CNT) cnt_q <= cnt_q + 1'b1;
  end

  assign blank_last_o = run_i && (cnt_q == BLANK_END);
  assign min_done_o   = run_i && (cnt_q == LAST_CNT);

  AST_CNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT); // R3
endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        left_q <= CNT_W'(1);
    else if (load_i)                    left_q <= (load_val_i == '0) ? CNT_W'(1) : load_val_i;
    else if (run_i && left_q > CNT_W'(1)) left_q <= left_q - 1'b1;
  end

  assign expire_o = (left_q <= CNT_W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (left_q != '0)); // R5
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !expire_o) |=> (left_q == $past(left_q) - 1'b1)); // R5
endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int BLANK_CYC  = 4,
  parameter int MIN_ON_CYC = 8,
  parameter int CNT_W      = 8,
  parameter int SYNC_STG   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] toff_i,
  output logic             bridge_on_o,
  output logic [1:0]       phase_o
);
  chop_state_e state_q, state_d;
  logic cmp_s, pend_q, pend_d, trip;
  logic on_run, blank_last, min_done, off_expire;

  chop_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  assign on_run = (state_q == ST_BLANK) || (state_q == ST_ON);

  chop_on_timer #(.BLANK_CYC(BLANK_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_on_tmr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (on_run),
    .blank_last_o(blank_last),
    .min_done_o  (min_done)
  );

  chop_off_timer #(.CNT_W(CNT_W)) u_off_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (trip),
    .load_val_i(toff_i),
    .run_i     (state_q == ST_OFF),
    .expire_o  (off_expire)
  );

  // blanking masks the comparator; a trip inside the min-on window is held pending
  assign trip = en_i && (state_q == ST_ON) && min_done && (pend_q || cmp_s);

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_DIS;
    end else begin
      unique case (state_q)
        ST_DIS:   state_d = ST_BLANK;
        ST_BLANK: if (blank_last) state_d = ST_ON;
        ST_ON:    if (trip)       state_d = ST_OFF;
        ST_OFF:   if (off_expire) state_d = ST_BLANK;
      endcase
    end
  end

  assign pend_d = (state_q == ST_ON) && (state_d == ST_ON) && (pend_q || cmp_s);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BLANK;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign bridge_on_o = en_i && on_run;
  assign phase_o     = state_q;

  AST_EN_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_DIS)); // R8
  AST_BLANK_NO_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BLANK) |=> (state_q != ST_OFF)); // R2
  AST_MIN_ON_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && !min_done) |=> (state_q != ST_OFF)); // R3
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_OFF && !off_expire) |=> (state_q == ST_OFF)); // R5
  AST_OFF_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_OFF && off_expire) |=> (state_q == ST_BLANK)); // R6
  AST_OFF_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_OFF) |-> ($past(state_q) == ST_ON)); // R4
endmodule

// File: tb/chop_ctrl_bench.sv
`timescale 1ns/100ps
module chop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BLANK  = 4;
  localparam int MIN_ON = 8;
  localparam int CW     = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b1, cmp = 1'b0;
  logic [CW-1:0] toff = CW'(5);
  logic bridge_on;
  logic [1:0] phase;

  always #(CLK_PERIOD/2) clk = ~clk;

  chop_ctrl #(.BLANK_CYC(BLANK), .MIN_ON_CYC(MIN_ON), .CNT_W(CW), .SYNC_STG(2)) u_chop_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .cmp_i(cmp), .toff_i(toff),
    .bridge_on_o(bridge_on), .phase_o(phase)
  );

  typedef struct { bit on; bit [1:0] ph; string tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // requirement-level model: mode 0 disabled, 1 on, 2 off
  int m_mode = 1, m_age = 0, m_left = 0;
  bit m_seen = 0, m_c1 = 0, m_c2 = 0;

  task automatic report(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit e, bit c, int t, string tag);
    exp_t x;
    bit hit;
    en = e; cmp = c; toff = CW'(t);
    if (!e) m_mode = 0;
    else begin
      case (m_mode)
        0: begin m_mode = 1; m_age = 0; m_seen = 0; end
        1: begin
          hit = m_c2 && (m_age >= BLANK);
          if (m_age >= MIN_ON-1 && (m_seen || hit)) begin
            m_mode = 2; m_left = (t == 0) ? 1 : t;
          end else begin
            m_seen = m_seen | hit; m_age++;
          end
        end
        default: begin
          if (m_left <= 1) begin m_mode = 1; m_age = 0; m_seen = 0; end
          else m_left--;
        end
      endcase
    end
    m_c2 = m_c1; m_c1 = c;
    x.on  = e && (m_mode == 1);
    x.ph  = (m_mode == 0) ? 2'b00 : (m_mode == 2) ? 2'b11 : (m_age < BLANK) ? 2'b01 : 2'b10;
    x.tag = tag;
    sb.push_back(x);
    if (!e) begin
      #1;
      report("R8", "bridge_on while disabled", int'(bridge_on), 0);
    end
    @(negedge clk);
  endtask

  task automatic fresh_on(int t);
    for (int i = 0; i < 100 && m_mode != 2; i++) step(1, 1, t, "R4");
    for (int i = 0; i < 300 && m_mode == 2; i++) step(1, 0, t, "R6");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        report(x.tag, "bridge_on_o", int'(bridge_on), int'(x.on));
        report(x.tag, "phase_o", int'(phase), int'(x.ph));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    report("R1", "reset bridge_on", int'(bridge_on), 1);
    report("R1", "reset phase", int'(phase), 1);
    rst_ni = 1'b1;
    // R1/R9: quiet comparator, blanking then plain on
    for (int i = 0; i < 4; i++) step(1, 0, 5, "R1");
    for (int i = 0; i < 8; i++) step(1, 0, 5, "R9");
    // R4/R5/R6: steady comparator, repeated trips
    for (int i = 0; i < 24; i++) step(1, 1, 5, "R4");
    for (int i = 0; i < 12; i++) step(1, 0, 5, "R6");
    // R2: pulse inside blanking is ignored
    fresh_on(5);
    step(1, 1, 5, "R2");
    for (int i = 0; i < 14; i++) step(1, 0, 5, "R2");
    // R3: pulse after blanking, before min-on, trips at min-on
    fresh_on(4);
    for (int i = 0; i < 20 && m_age < BLANK-1; i++) step(1, 0, 4, "R3");
    step(1, 1, 4, "R3");
    for (int i = 0; i < 14; i++) step(1, 0, 4, "R3");
    // R7: new off value applies at the next trip only
    fresh_on(3);
    for (int i = 0; i < 100 && m_mode != 2; i++) step(1, 1, 3, "R7");
    for (int i = 0; i < 30; i++) step(1, 1, 9, "R7");
    // R5: zero off count gives one cycle
    for (int i = 0; i < 24; i++) step(1, 1, 0, "R5");
    // R8: disable during off and during on
    fresh_on(6);
    for (int i = 0; i < 100 && m_mode != 2; i++) step(1, 1, 6, "R8");
    step(1, 1, 6, "R8");
    for (int i = 0; i < 3; i++) step(0, 0, 6, "R8");
    for (int i = 0; i < 7; i++) step(1, 0, 6, "R8");
    for (int i = 0; i < 2; i++) step(0, 0, 6, "R8");
    for (int i = 0; i < 10; i++) step(1, 0, 6, "R8");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule